// File: doc/BRIEF.md
# OTP and Emulation Page Copy Sequencer

This block runs page-copy commands against two page memories: a one-time-programmable (OTP) array and an emulation array that stands in for it. Each command copies either one chosen page or every page from the selected array into a bank of shadow page registers. A host reads those registers through the block's register port. Copy commands are honoured only in a dedicated programming state. That state can be entered only from OFF, and only a device reset leaves it.

When the block enters the programming state, it bulk-copies the whole OTP array into the shadow bank without being asked, which replaces whatever the bank held before. While any copy sequence is running, the register port is locked: writes are discarded and reads return zero. When a sequence finishes, a sticky interrupt flag is set, and the host clears it.

Both memories are simple synchronous read ports. Their read latency is a parameter; the default is one cycle. The page count, page width and address width are parameters too.

Top module: `nvm_cmd_seq`

## Requirements
- R1: After reset, main_state is 5'b00000 (OFF), irq is 0, neither memory read enable is asserted, and every shadow page reads 0.
- R2: A host write to address 0 with bit 15 set, made while in OFF, moves main_state to 5'b01011 (programming) in the next cycle. main_state changes by no other means.
- R3: Entering the programming state starts an automatic copy of every OTP page into the shadow page of the same index, using read level 2'b00. The copy overwrites earlier shadow contents, and it sets irq when it finishes.
- R4: Once in the programming state, the block stays there. Any register write leaves it unchanged, including another write with bit 15 set. Only rst_n returns it to OFF and clears the shadow bank.
- R5: In the programming state, a write to address 0 with bit 8 = 1 and bit 15 = 0 starts a copy. Bit 13 = 1 selects the OTP array and bit 13 = 0 selects the emulation array. 16'h2120 copies all OTP pages, and 16'h0120 copies all emulation pages.
- R6: Bit 5 = 1 copies every page. Bit 5 = 0 copies only the page whose index is in bits [PIDX_W-1:0] (bits [2:0] by default), and all other shadow pages keep their values.
- R7: Bits [11:10] are the read level. During an OTP copy they are driven on otp_rd_lvl. An emulation copy gives the same shadow contents whatever these bits hold.
- R8: While a copy sequence runs, host_rdata is 0 and every host write is discarded. A command written during that time never runs.
- R9: irq is set in the cycle after a copy sequence's last page is stored. It stays set until the host writes a word with bit 0 = 1 to address 1. Reading address 1 returns irq in bit 0.
- R10: A copy command written in OFF, or a word with both bit 8 and bit 15 set written in the programming state, starts no memory read, changes no shadow page and does not set irq.
- R11: Reading address 2**(ADDR_W-1)+p returns shadow page p, zero-extended to 16 bits (address 8+p by default).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low device reset |
| host_wr_en | input | 1 | Host register write strobe |
| host_addr | input | ADDR_W | Host register address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data for host_addr (combinational) |
| main_state | output | 5 | Main state code: 5'b00000 OFF, 5'b01011 programming |
| irq | output | 1 | Sticky completion interrupt flag |
| otp_rd_en | output | 1 | OTP array read enable |
| otp_rd_addr | output | PIDX_W | OTP array page index |
| otp_rd_lvl | output | 2 | OTP read level |
| otp_rd_data | input | PAGE_W | OTP read data, MEM_LAT cycles after the enable |
| emu_rd_en | output | 1 | Emulation array read enable |
| emu_rd_addr | output | PIDX_W | Emulation array page index |
| emu_rd_data | input | PAGE_W | Emulation read data, MEM_LAT cycles after the enable |

## Verification
The copy function is run with an OTP array and an emulation array that hold different contents, so every shadow page shows which array filled it. A single-page OTP copy uses a non-zero read level, and the bench model folds that level into the returned data; this shows that the level reaches the OTP port and that no neighbouring page is touched. An emulation bulk copy with the level bits set to 2'b11 must still return the plain emulation data. Commands written in OFF, commands written while busy, and commands with the program-request bit set are each followed by an idle window, a check that irq stays low and a readback of the shadow bank, so that a command wrongly accepted would show.

// File: rtl/nvm_seq_pkg.sv
package nvm_seq_pkg;
   localparam int REG_W     = 16;
   // control word bit positions
   localparam int B_PROG    = 15;
   localparam int B_MEMSEL  = 13;
   localparam int B_LVL_HI  = 11;
   localparam int B_LVL_LO  = 10;
   localparam int B_READ    = 8;
   localparam int B_BULK    = 5;
   // register addresses
   localparam int A_CTRL    = 0;
   localparam int A_IRQ     = 1;
   // main state codes
   localparam logic [4:0] MS_OFF  = 5'b00000;
   localparam logic [4:0] MS_PROG = 5'b01011;

   typedef enum logic [1:0] {
      ENG_IDLE  = 2'd0,
      ENG_RUN   = 2'd1,
      ENG_DRAIN = 2'd2
   } eng_state_t;
endpackage

// File: rtl/nvm_host_decode.sv
module nvm_host_decode
   import nvm_seq_pkg::*;
#(
   parameter int ADDR_W  = 4,
   parameter int PIDX_W  = 3
) (
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [REG_W-1:0]  wdata,
   input  logic              busy,
   input  logic              in_prog,
   output logic              enter_prog,
   output logic              cmd_go,
   output logic              cmd_otp,
   output logic              cmd_bulk,
   output logic [PIDX_W-1:0] cmd_page,
   output logic [1:0]        cmd_lvl,
   output logic              irq_clr
);
   logic ctrl_hit;
   logic irq_hit;
   logic unused_wdata;

   assign ctrl_hit   = wr_en && !busy && (addr == ADDR_W'(A_CTRL));
   assign irq_hit    = wr_en && !busy && (addr == ADDR_W'(A_IRQ));

   assign enter_prog = ctrl_hit && !in_prog && wdata[B_PROG];
   assign cmd_go     = ctrl_hit &&  in_prog && wdata[B_READ] && !wdata[B_PROG];
   assign cmd_otp    = wdata[B_MEMSEL];
   assign cmd_bulk   = wdata[B_BULK];
   assign cmd_page   = wdata[PIDX_W-1:0];
   assign cmd_lvl    = wdata[B_LVL_HI:B_LVL_LO];
   assign irq_clr    = irq_hit && wdata[0];

   assign unused_wdata = ^wdata;
endmodule

// File: rtl/nvm_copy_engine.sv
module nvm_copy_engine
   import nvm_seq_pkg::*;
#(
   parameter int NUM_PAGES = 8,
   parameter int PAGE_W    = 16,
   parameter int MEM_LAT   = 1,
   parameter int PIDX_W    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              start_otp,
   input  logic              start_bulk,
   input  logic [PIDX_W-1:0] start_page,
   input  logic [1:0]        start_lvl,
   output logic              busy,
   output logic              done,
   output logic              otp_rd_en,
   output logic [PIDX_W-1:0] otp_rd_addr,
   output logic [1:0]        otp_rd_lvl,
   input  logic [PAGE_W-1:0] otp_rd_data,
   output logic              emu_rd_en,
   output logic [PIDX_W-1:0] emu_rd_addr,
   input  logic [PAGE_W-1:0] emu_rd_data,
   output logic              sh_we,
   output logic [PIDX_W-1:0] sh_addr,
   output logic [PAGE_W-1:0] sh_data
);
   localparam logic [PIDX_W-1:0] LAST_PAGE = PIDX_W'(NUM_PAGES - 1);

   eng_state_t        st;
   logic [PIDX_W-1:0] cur;
   logic [PIDX_W-1:0] last;
   logic              sel_otp;
   logic [1:0]        lvl_q;
   logic              issue;
   logic              pend_early;
   logic [MEM_LAT-1:0] pv;
   logic [PIDX_W-1:0] pa [MEM_LAT];

   assign issue = (st == ENG_RUN);
   assign busy  = (st != ENG_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ENG_IDLE;
         cur     <= '0;
         last    <= '0;
         sel_otp <= 1'b0;
         lvl_q   <= 2'b00;
      end else begin
         case (st)
            ENG_IDLE: if (start) begin
               sel_otp <= start_otp;
               lvl_q   <= start_lvl;
               cur     <= start_bulk ? '0 : start_page;
               last    <= start_bulk ? LAST_PAGE : start_page;
               st      <= ENG_RUN;
            end
            ENG_RUN: begin
               cur <= cur + 1'b1;
               if (cur == last) st <= ENG_DRAIN;
            end
            ENG_DRAIN: if (done) st <= ENG_IDLE;
            default: st <= ENG_IDLE;
         endcase
      end
   end

   // read-latency pipeline carrying the page index to the capture stage
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pv <= '0;
         for (int i = 0; i < MEM_LAT; i++) pa[i] <= '0;
      end else begin
         pv[0] <= issue;
         pa[0] <= cur;
         for (int i = 1; i < MEM_LAT; i++) begin
            pv[i] <= pv[i-1];
            pa[i] <= pa[i-1];
         end
      end
   end

   generate
      if (MEM_LAT == 1) begin : g_lat_one
         assign pend_early = 1'b0;
      end else begin : g_lat_multi
         assign pend_early = |pv[MEM_LAT-2:0];
      end
   endgenerate

   assign done        = (st == ENG_DRAIN) && pv[MEM_LAT-1] && !pend_early;

   assign otp_rd_en   = issue && sel_otp;
   assign otp_rd_addr = cur;
   assign otp_rd_lvl  = lvl_q;
   assign emu_rd_en   = issue && !sel_otp;
   assign emu_rd_addr = cur;

   assign sh_we       = pv[MEM_LAT-1];
   assign sh_addr     = pa[MEM_LAT-1];
   assign sh_data     = sel_otp ? otp_rd_data : emu_rd_data;
endmodule

// File: rtl/nvm_shadow_bank.sv
module nvm_shadow_bank #(
   parameter int NUM_PAGES = 8,
   parameter int PAGE_W    = 16,
   parameter int PIDX_W    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [PIDX_W-1:0] waddr,
   input  logic [PAGE_W-1:0] wdata,
   input  logic [PIDX_W-1:0] raddr,
   output logic [PAGE_W-1:0] rdata
);
   logic [PAGE_W-1:0] pg [NUM_PAGES];

   generate
      for (genvar g = 0; g < NUM_PAGES; g++) begin : g_page
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                             pg[g] <= '0;
            else if (we && waddr == PIDX_W'(g))     pg[g] <= wdata;
         end
      end
   endgenerate

   assign rdata = pg[raddr];
endmodule

// File: rtl/nvm_cmd_seq.sv
module nvm_cmd_seq
   import nvm_seq_pkg::*;
#(
   parameter int ADDR_W    = 4,
   parameter int NUM_PAGES = 8,
   parameter int PAGE_W    = 16,
   parameter int MEM_LAT   = 1,
   localparam int PIDX_W   = $clog2(NUM_PAGES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr_en,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [15:0]       host_wdata,
   output logic [15:0]       host_rdata,
   output logic [4:0]        main_state,
   output logic              irq,
   output logic              otp_rd_en,
   output logic [PIDX_W-1:0] otp_rd_addr,
   output logic [1:0]        otp_rd_lvl,
   input  logic [PAGE_W-1:0] otp_rd_data,
   output logic              emu_rd_en,
   output logic [PIDX_W-1:0] emu_rd_addr,
   input  logic [PAGE_W-1:0] emu_rd_data
);
   localparam logic [ADDR_W-1:0] SH_BASE = ADDR_W'(1) << (ADDR_W - 1);

   generate
      if (NUM_PAGES < 2 || (NUM_PAGES & (NUM_PAGES - 1)) != 0) begin : g_bad_pages
         $error("NUM_PAGES must be a power of two of at least 2");
      end
      if (NUM_PAGES > (1 << (ADDR_W - 1))) begin : g_bad_addr
         $error("shadow window of ADDR_W cannot hold NUM_PAGES");
      end
      if (PAGE_W > REG_W || PAGE_W < 1) begin : g_bad_width
         $error("PAGE_W must be 1..16");
      end
      if (MEM_LAT < 1) begin : g_bad_lat
         $error("MEM_LAT must be at least 1");
      end
   endgenerate

   logic              in_prog;
   logic              eng_busy, eng_done;
   logic              enter_prog, cmd_go, cmd_otp, cmd_bulk, irq_clr;
   logic [PIDX_W-1:0] cmd_page;
   logic [1:0]        cmd_lvl;
   logic              st_go, st_otp, st_bulk;
   logic [PIDX_W-1:0] st_page;
   logic [1:0]        st_lvl;
   logic              sh_we;
   logic [PIDX_W-1:0] sh_waddr;
   logic [PAGE_W-1:0] sh_wdata, sh_rdata;
   logic              sh_hit;

   nvm_host_decode #(.ADDR_W(ADDR_W), .PIDX_W(PIDX_W)) u_dec (
      .wr_en(host_wr_en), .addr(host_addr), .wdata(host_wdata),
      .busy(eng_busy), .in_prog(in_prog),
      .enter_prog(enter_prog), .cmd_go(cmd_go), .cmd_otp(cmd_otp),
      .cmd_bulk(cmd_bulk), .cmd_page(cmd_page), .cmd_lvl(cmd_lvl),
      .irq_clr(irq_clr)
   );

   // entry forces an OTP bulk copy at the normal read level
   assign st_go   = enter_prog || cmd_go;
   assign st_otp  = enter_prog ? 1'b1  : cmd_otp;
   assign st_bulk = enter_prog ? 1'b1  : cmd_bulk;
   assign st_page = enter_prog ? '0    : cmd_page;
   assign st_lvl  = enter_prog ? 2'b00 : cmd_lvl;

   nvm_copy_engine #(
      .NUM_PAGES(NUM_PAGES), .PAGE_W(PAGE_W), .MEM_LAT(MEM_LAT), .PIDX_W(PIDX_W)
   ) u_eng (
      .clk(clk), .rst_n(rst_n),
      .start(st_go), .start_otp(st_otp), .start_bulk(st_bulk),
      .start_page(st_page), .start_lvl(st_lvl),
      .busy(eng_busy), .done(eng_done),
      .otp_rd_en(otp_rd_en), .otp_rd_addr(otp_rd_addr), .otp_rd_lvl(otp_rd_lvl),
      .otp_rd_data(otp_rd_data),
      .emu_rd_en(emu_rd_en), .emu_rd_addr(emu_rd_addr), .emu_rd_data(emu_rd_data),
      .sh_we(sh_we), .sh_addr(sh_waddr), .sh_data(sh_wdata)
   );

   nvm_shadow_bank #(.NUM_PAGES(NUM_PAGES), .PAGE_W(PAGE_W), .PIDX_W(PIDX_W)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .we(sh_we), .waddr(sh_waddr), .wdata(sh_wdata),
      .raddr(host_addr[PIDX_W-1:0]), .rdata(sh_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_prog <= 1'b0;
         irq     <= 1'b0;
      end else begin
         if (enter_prog) in_prog <= 1'b1;
         if (eng_done)     irq <= 1'b1;
         else if (irq_clr) irq <= 1'b0;
      end
   end

   assign main_state = in_prog ? MS_PROG : MS_OFF;

   assign sh_hit = host_addr[ADDR_W-1] &&
                   ((host_addr - SH_BASE) < ADDR_W'(NUM_PAGES));

   always_comb begin
      host_rdata = '0;
      if (!eng_busy) begin
         if (host_addr == ADDR_W'(A_IRQ)) host_rdata = {15'd0, irq};
         else if (sh_hit)                 host_rdata = REG_W'(sh_rdata);
      end
   end
endmodule

// File: rtl/nvm_cmd_seq_chk.sv
module nvm_cmd_seq_chk #(
   parameter int ADDR_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              host_wr_en,
   input logic [ADDR_W-1:0] host_addr,
   input logic [15:0]       host_wdata,
   input logic [15:0]       host_rdata,
   input logic [4:0]        main_state,
   input logic              irq,
   input logic              otp_rd_en,
   input logic              emu_rd_en,
   input logic              busy
);
   AST_ENTRY_BY_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
      (main_state == 5'b00000 &&
       !(host_wr_en && host_addr == '0 && host_wdata[15])) |=> main_state == 5'b00000); // R2

   AST_PROG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      main_state == 5'b01011 |=> main_state == 5'b01011); // R4

   AST_NO_READ_IN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      main_state == 5'b00000 |-> !otp_rd_en && !emu_rd_en); // R10

   AST_ONE_ARRAY: assert property (@(posedge clk) disable iff (!rst_n)
      !(otp_rd_en && emu_rd_en)); // R5

   AST_BUSY_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> host_rdata == 16'h0000); // R8

   AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !(host_wr_en && host_addr == ADDR_W'(1) && host_wdata[0])) |=> irq); // R9

   AST_IRQ_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(busy)); // R9
endmodule

bind nvm_cmd_seq nvm_cmd_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .host_wr_en(host_wr_en), .host_addr(host_addr),
   .host_wdata(host_wdata), .host_rdata(host_rdata), .main_state(main_state),
   .irq(irq), .otp_rd_en(otp_rd_en), .emu_rd_en(emu_rd_en), .busy(eng_busy)
);

// File: tb/nvm_cmd_seq_test.sv
module nvm_cmd_seq_test;
   localparam int AW = 4;
   localparam int NP = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_wr_en = 1'b0;
   logic [AW-1:0] host_addr = '0;
   logic [15:0] host_wdata = '0;
   logic [15:0] host_rdata;
   logic [4:0]  main_state;
   logic        irq;
   logic        otp_rd_en, emu_rd_en;
   logic [2:0]  otp_rd_addr, emu_rd_addr;
   logic [1:0]  otp_rd_lvl;
   logic [15:0] otp_rd_data = 16'hDEAD;
   logic [15:0] emu_rd_data = 16'hDEAD;

   logic [15:0] otp_arr [NP];
   logic [15:0] emu_arr [NP];
   logic [15:0] exp_sh  [NP];

   int checks = 0;
   int failures = 0;
   bit finished = 0;

   typedef struct {
      string       tag;
      logic [3:0]  addr;
      logic [15:0] exp;
   } item_t;
   item_t sb [$];

   always #2 clk = ~clk;   // 250 MHz

   nvm_cmd_seq uut (
      .clk(clk), .rst_n(rst_n), .host_wr_en(host_wr_en), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .main_state(main_state),
      .irq(irq), .otp_rd_en(otp_rd_en), .otp_rd_addr(otp_rd_addr),
      .otp_rd_lvl(otp_rd_lvl), .otp_rd_data(otp_rd_data), .emu_rd_en(emu_rd_en),
      .emu_rd_addr(emu_rd_addr), .emu_rd_data(emu_rd_data)
   );

   // behavioural arrays, one cycle read latency; OTP level folds into bits 15:14
   always @(posedge clk) begin
      otp_rd_data <= otp_rd_en ? (otp_arr[otp_rd_addr] ^ {otp_rd_lvl, 14'd0}) : 16'hDEAD;
      emu_rd_data <= emu_rd_en ? emu_arr[emu_rd_addr] : 16'hDEAD;
   end

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
      @(negedge clk);
      host_wr_en = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_wr_en = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [15:0] v);
      @(negedge clk);
      host_addr = a;
      #1 v = host_rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_irq(input string tag);
      int n = 0;
      while (irq !== 1'b1 && n < 40) begin @(negedge clk); n++; end
      chk({tag, " irq on completion"}, {15'd0, irq}, 16'h0001);
   endtask

   // driver side: push expected shadow contents
   task automatic push_pages(input string tag);
      for (int p = 0; p < NP; p++) begin
         item_t it;
         it.tag = $sformatf("%s page%0d", tag, p);
         it.addr = 4'(8 + p);
         it.exp = exp_sh[p];
         sb.push_back(it);
      end
   endtask

   // monitor side: pop each expected item and compare with the readback
   task automatic monitor();
      logic [15:0] v;
      while (sb.size() > 0) begin
         item_t it = sb.pop_front();
         rd(it.addr, v);
         chk(it.tag, v, it.exp);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [15:0] v;
      for (int p = 0; p < NP; p++) begin
         otp_arr[p] = 16'h3100 + 16'(p) * 16'h0203;
         emu_arr[p] = 16'h0C40 + 16'(p) * 16'h1111;
         exp_sh[p]  = 16'h0000;
      end
      idle(3);
      rst_n = 1'b1;
      idle(1);

      // R1 reset state
      chk("R1 main_state OFF", {11'd0, main_state}, 16'h0000);
      chk("R1 irq low", {15'd0, irq}, 16'h0000);
      chk("R1 read enables idle", {14'd0, otp_rd_en, emu_rd_en}, 16'h0000);
      push_pages("R1 R11 reset shadow");
      monitor();

      // R10 command in OFF is ignored
      wr(0, 16'h2120);
      idle(12);
      chk("R10 no irq for command in OFF", {15'd0, irq}, 16'h0000);
      chk("R10 still OFF", {11'd0, main_state}, 16'h0000);
      push_pages("R10 shadow untouched in OFF");
      monitor();

      // R2 R3 entry with automatic OTP bulk copy
      wr(0, 16'h8000);
      chk("R2 main_state programming", {11'd0, main_state}, 16'h000B);
      host_addr = 4'd8;
      #1 chk("R8 read returns zero while busy", host_rdata, 16'h0000);
      wr(0, 16'h0120);               // dropped, engine busy
      wait_irq("R3");
      idle(3);
      chk("R9 irq held", {15'd0, irq}, 16'h0001);
      rd(1, v);
      chk("R9 irq readback", v, 16'h0001);
      wr(1, 16'h0000);
      chk("R9 writing 0 keeps irq", {15'd0, irq}, 16'h0001);
      wr(1, 16'h0001);
      chk("R9 irq cleared", {15'd0, irq}, 16'h0000);
      idle(12);
      chk("R8 busy-time command never ran", {15'd0, irq}, 16'h0000);
      for (int p = 0; p < NP; p++) exp_sh[p] = otp_arr[p];
      push_pages("R3 R8 entry copy");
      monitor();

      // R6 R7 single OTP page with level 01
      otp_arr[3] = 16'h2468;
      otp_arr[4] = 16'h1357;          // neighbour changed but not copied
      wr(0, 16'h2503);
      wait_irq("R6");
      wr(1, 16'h0001);
      exp_sh[3] = 16'h2468 ^ 16'h4000;
      push_pages("R6 R7 single OTP page");
      monitor();

      // R5 R7 emulation bulk copy with level bits set
      wr(0, 16'h0D20);
      wait_irq("R5");
      wr(1, 16'h0001);
      for (int p = 0; p < NP; p++) exp_sh[p] = emu_arr[p];
      push_pages("R5 R7 emu bulk");
      monitor();

      // R6 single emulation page
      emu_arr[5] = 16'hBEEF;
      emu_arr[6] = 16'hCAFE;
      wr(0, 16'h0105);
      wait_irq("R6 emu");
      wr(1, 16'h0001);
      exp_sh[5] = 16'hBEEF;
      push_pages("R6 single emu page");
      monitor();

      // R5 OTP bulk by its command word
      wr(0, 16'h2120);
      wait_irq("R5 otp");
      wr(1, 16'h0001);
      for (int p = 0; p < NP; p++) exp_sh[p] = otp_arr[p];
      push_pages("R5 OTP bulk");
      monitor();

      // R10 R4 command with program bit, re-entry request
      emu_arr[0] = 16'h7777;
      wr(0, 16'h8120);
      idle(12);
      chk("R10 program+read ignored", {15'd0, irq}, 16'h0000);
      wr(0, 16'h8000);
      idle(12);
      chk("R4 stays programming", {11'd0, main_state}, 16'h000B);
      chk("R4 re-request starts nothing", {15'd0, irq}, 16'h0000);
      wr(0, 16'h0000);
      chk("R4 zero write keeps state", {11'd0, main_state}, 16'h000B);
      push_pages("R10 shadow unchanged");
      monitor();

      // R4 R1 only reset leaves
      @(negedge clk); rst_n = 1'b0;
      idle(2);
      rst_n = 1'b1;
      idle(1);
      chk("R4 reset returns to OFF", {11'd0, main_state}, 16'h0000);
      chk("R1 irq low after reset", {15'd0, irq}, 16'h0000);
      for (int p = 0; p < NP; p++) exp_sh[p] = 16'h0000;
      push_pages("R1 shadow cleared");
      monitor();

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule